// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog timer that a host controls through a 64-byte register window with a simple write strobe and a combinational read port. The host loads two preload values and picks a prescaler. It then chooses what happens on expiry and starts the timer. After that, the host must restart the timer at intervals to keep it from expiring. The preloads and the reload/flag byte are guarded. A write to any of them takes effect only if the two-byte unlock sequence came immediately before it. A lock bit can freeze the whole configuration until the next hardware reset.

Counting has two stages. The first stage counts down from the first preload. When it runs out, the block raises an interrupt output and continues from the second preload. When the second stage runs out, the block sets a sticky timeout flag. It can also pulse one of two reset outputs and drive a timeout pin. The timeout flag has its own power-on reset, so it survives the watchdog reset it caused and software can read it after restart.

Top module: `lockable_watchdog`

## Requirements
- R1: After `rst_n` is low at a clock edge, the preloads (0x00, 0x04), configuration (0x10), lock register (0x18) and counter readback (0x14) read 0, and the interrupt and reset outputs are low.
- R2: Writing 0x80 and then 0x86 to offset 0x0C, on consecutive writes, opens the gate. The next write to a guarded offset (0x00, 0x04, 0x0D) takes effect.
- R3: A guarded write that does not immediately follow a complete unlock is ignored. This includes a sequence cancelled by any other write between 0x80 and 0x86.
- R4: An open gate is consumed by the next write of any kind. A second guarded write needs a fresh unlock.
- R5: Offsets 0x10 and 0x18 are written without unlock. Configuration bit 2 selects the fine prescaler (1) or the coarse one (0). Bit 3 selects the warm reset output (1) or the cold one (0). Bit 4 enables the reset pulse. Bit 5 enables the timeout pin. These bits read back in place.
- R6: Lock register bit 0, once set, makes writes to 0x00, 0x04, 0x10 and 0x18 ignored until `rst_n`, and software cannot clear it.
- R7: With lock register bit 1 set, the counter steps once every 2^COARSE_SHIFT clocks (coarse) or every 2^FINE_SHIFT clocks (fine). The first stage expires P1+1 steps after enable. Expiry raises `stage1_irq_o` and loads P2.
- R8: The second stage expires P2+1 steps later. Expiry sets the timeout flag (bit 1 of 0x0D). If bit 4 is set, it also pulses the selected reset output for exactly one cycle. `tout_o` equals the flag AND configuration bit 5.
- R9: A guarded write with bit 0 set at 0x0D restarts counting from P1 in stage one and clears `stage1_irq_o`. A reload on the same edge as a second-stage expiry wins, and no timeout occurs.
- R10: The timeout flag is cleared only by a guarded write of 1 to bit 1 of 0x0D, or by `por_n`. It survives `rst_n`.
- R11: After a timeout, the counter halts at 0 if lock register bit 2 is 0. If that bit is 1, the counter restarts from P1.
- R12: While the timer is disabled, the counter readback at 0x14 shows P1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| por_n | input | 1 | Synchronous active-low power-on reset, clears the timeout flag |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 6 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data, byte registers use bits 7:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| stage1_irq_o | output | 1 | High after a first-stage expiry until reload or disable |
| tout_o | output | 1 | Timeout pin: flag gated by its enable |
| rst_cold_o | output | 1 | One-cycle cold reset request on timeout |
| rst_warm_o | output | 1 | One-cycle warm reset request on timeout |

## Verification
A reload from the host and the second-stage expiry can land on the same clock edge. The bench counts the exact edge of expiry from the enabling write. It then places the two unlock writes on the two edges before that edge, so the reload write lands on the expiry edge itself. The result is judged at the ports: the timeout pin must stay low and the counter readback must show the first preload again. Without the reload, the same configuration expires on that edge, and a separate timing sweep confirms this.

// File: rtl/wdl_pkg.sv
// Package: shared offsets, unlock keys and state type for the watchdog.
// Assumes a 64-byte window addressed by byte offset.
package wdl_pkg;
    localparam int ADDR_W = 6;
    typedef logic [ADDR_W-1:0] wdl_addr_t;

    localparam wdl_addr_t OFS_PV1 = 6'h00;
    localparam wdl_addr_t OFS_PV2 = 6'h04;
    localparam wdl_addr_t OFS_RR0 = 6'h0C;
    localparam wdl_addr_t OFS_RR1 = 6'h0D;
    localparam wdl_addr_t OFS_CFG = 6'h10;
    localparam wdl_addr_t OFS_CNT = 6'h14;
    localparam wdl_addr_t OFS_LCK = 6'h18;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } ul_state_t;
endpackage

// File: rtl/wdl_unlock.sv
// Module: unlock gate. Tracks the two-write key sequence at the key offset
// and reports when the very next write may touch a guarded register.
// Assumes one write per strobe cycle; reads do not disturb the sequence.
module wdl_unlock
    import wdl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  wdl_addr_t addr_i,
    input  logic [7:0] wdata_i,
    output logic      open_o
);
    ul_state_t state_q, state_d;

    // Next-state: any write either advances the key sequence or cancels it.
    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            if (state_q == UL_HALF && addr_i == OFS_RR0 && wdata_i == KEY_SECOND)
                state_d = UL_OPEN;
            else if (addr_i == OFS_RR0 && wdata_i == KEY_FIRST)
                state_d = UL_HALF;
            else
                state_d = UL_IDLE;
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UL_IDLE;
        else        state_q <= state_d;
    end

    assign open_o = (state_q == UL_OPEN);

    assert_gate_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && state_q == UL_OPEN) |=> (state_q != UL_OPEN));

    assert_gate_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(wr_i && addr_i == OFS_RR0 && wdata_i == KEY_SECOND));
endmodule

// File: rtl/wdl_counter.sv
// Module: two-stage prescaled down counter. A free-running prescaler gives a
// step every 2^COARSE_SHIFT or 2^FINE_SHIFT clocks; stage one counts from
// pv1, stage two from pv2. Assumes FINE_SHIFT < COARSE_SHIFT.
// expire_o is a same-cycle strobe so the parent registers flag and pulse.
module wdl_counter #(
    parameter int DATA_W       = 32,
    parameter int COARSE_SHIFT = 15,
    parameter int FINE_SHIFT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              fine_i,
    input  logic              reload_i,
    input  logic              restart_i,
    input  logic [DATA_W-1:0] pv1_i,
    input  logic [DATA_W-1:0] pv2_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              irq_o,
    output logic              expire_o
);
    logic [COARSE_SHIFT-1:0] pre_q;
    logic [DATA_W-1:0]       cnt_q;
    logic                    stage_q;
    logic                    halt_q;
    logic                    irq_q;
    logic                    tick;
    logic                    run;
    logic                    at_zero;

    assign tick     = fine_i ? (&pre_q[FINE_SHIFT-1:0]) : (&pre_q);
    assign run      = en_i && !reload_i && !halt_q;
    assign at_zero  = (cnt_q == '0);
    assign expire_o = run && tick && at_zero && stage_q;

    // Counter, stage and prescaler update; disable and reload take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            stage_q <= 1'b0;
            halt_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else if (!en_i || reload_i) begin
            pre_q   <= '0;
            cnt_q   <= pv1_i;
            stage_q <= 1'b0;
            halt_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else if (!halt_q) begin
            pre_q <= pre_q + 1'b1;
            if (tick) begin
                if (!at_zero) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (!stage_q) begin
                    stage_q <= 1'b1;
                    cnt_q   <= pv2_i;
                    irq_q   <= 1'b1;
                end else if (restart_i) begin
                    stage_q <= 1'b0;
                    cnt_q   <= pv1_i;
                end else begin
                    halt_q <= 1'b1;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign irq_o = irq_q;

    assert_stage_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && at_zero && !stage_q) |=> (stage_q && irq_q && cnt_q == $past(pv2_i)));

    assert_reload_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && reload_i) |=> (!stage_q && !irq_q && cnt_q == $past(pv1_i)));

    assert_halt_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && en_i && !reload_i) |=> ($stable(cnt_q) && halt_q));
endmodule

// File: rtl/lockable_watchdog.sv
// Module: watchdog top. Decodes the register window, applies the unlock gate
// and the lock, holds the sticky timeout flag (power-on reset only) and
// registers the reset pulses. Assumes one write per bus_wr cycle.
module lockable_watchdog
    import wdl_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int COARSE_SHIFT = 15,
    parameter int FINE_SHIFT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              stage1_irq_o,
    output logic              tout_o,
    output logic              rst_cold_o,
    output logic              rst_warm_o
);
    localparam int CFG_LSB = 2;
    localparam int CFG_W   = 4;
    localparam int LCK_W   = 3;

    logic [DATA_W-1:0] pv1_q, pv2_q, cnt;
    logic [CFG_W-1:0]  cfg_q;   // {tout_en, rst_en, warm_sel, fine_sel}
    logic [LCK_W-1:0]  lock_q;  // {restart, enable, lock}
    logic              flag_q, cold_q, warm_q;
    logic              gate_open, frozen, expire;
    logic              wr_pv1, wr_pv2, wr_rr1, wr_cfg, wr_lck;
    logic              reload, flag_clr;

    wdl_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata[7:0]),
        .open_o  (gate_open)
    );

    assign frozen   = lock_q[0];
    assign wr_pv1   = bus_wr && bus_addr == OFS_PV1 && gate_open && !frozen;
    assign wr_pv2   = bus_wr && bus_addr == OFS_PV2 && gate_open && !frozen;
    assign wr_rr1   = bus_wr && bus_addr == OFS_RR1 && gate_open;
    assign wr_cfg   = bus_wr && bus_addr == OFS_CFG && !frozen;
    assign wr_lck   = bus_wr && bus_addr == OFS_LCK && !frozen;
    assign reload   = wr_rr1 && bus_wdata[0];
    assign flag_clr = wr_rr1 && bus_wdata[1];

    wdl_counter #(
        .DATA_W       (DATA_W),
        .COARSE_SHIFT (COARSE_SHIFT),
        .FINE_SHIFT   (FINE_SHIFT)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (lock_q[1]),
        .fine_i    (cfg_q[0]),
        .reload_i  (reload),
        .restart_i (lock_q[2]),
        .pv1_i     (pv1_q),
        .pv2_i     (pv2_q),
        .cnt_o     (cnt),
        .irq_o     (stage1_irq_o),
        .expire_o  (expire)
    );

    // Configuration registers written through the window, cleared by rst_n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv1_q  <= '0;
            pv2_q  <= '0;
            cfg_q  <= '0;
            lock_q <= '0;
        end else begin
            if (wr_pv1) pv1_q  <= bus_wdata;
            if (wr_pv2) pv2_q  <= bus_wdata;
            if (wr_cfg) cfg_q  <= bus_wdata[CFG_LSB +: CFG_W];
            if (wr_lck) lock_q <= bus_wdata[LCK_W-1:0];
        end
    end

    // Sticky timeout flag: only power-on reset or a guarded clear drops it.
    always_ff @(posedge clk) begin
        if (!por_n)        flag_q <= 1'b0;
        else if (expire)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // One-cycle reset request on the output picked by the reset-type bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cold_q <= 1'b0;
            warm_q <= 1'b0;
        end else begin
            cold_q <= expire && cfg_q[2] && !cfg_q[1];
            warm_q <= expire && cfg_q[2] &&  cfg_q[1];
        end
    end

    // Read multiplexer over the window.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PV1: bus_rdata = pv1_q;
            OFS_PV2: bus_rdata = pv2_q;
            OFS_RR1: bus_rdata[1] = flag_q;
            OFS_CFG: bus_rdata[CFG_LSB +: CFG_W] = cfg_q;
            OFS_CNT: bus_rdata = cnt;
            OFS_LCK: bus_rdata[LCK_W-1:0] = lock_q;
            default: bus_rdata = '0;
        endcase
    end

    assign tout_o     = flag_q && cfg_q[3];
    assign rst_cold_o = cold_q;
    assign rst_warm_o = warm_q;

    assert_guarded_needs_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PV1 && !gate_open) |=> $stable(pv1_q));

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[0] |=> lock_q[0]);

    assert_lock_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[0] |=> ($stable(cfg_q) && $stable(pv1_q) && $stable(pv2_q)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
        (flag_q && !flag_clr) |=> flag_q);

    assert_one_reset_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_cold_o, rst_warm_o}));
endmodule

// File: tb/tb_lockable_watchdog.sv
`timescale 1ns/1ps
module tb_lockable_watchdog;
    localparam int DW = 32;
    localparam int CS = 4;
    localparam int FS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          stage1_irq_o, tout_o, rst_cold_o, rst_warm_o;

    int checks = 0;
    int fails  = 0;

    lockable_watchdog #(.DATA_W(DW), .COARSE_SHIFT(CS), .FINE_SHIFT(FS)) dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stage1_irq_o(stage1_irq_o), .tout_o(tout_o),
        .rst_cold_o(rst_cold_o), .rst_warm_o(rst_warm_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output longint v);
        bus_addr = a; #0.5;
        v = bus_rdata;
    endtask

    task automatic unlock();
        wr(6'h0C, 32'h80);
        wr(6'h0C, 32'h86);
    endtask

    // Programs a run; the enabling write is the last edge, called E.
    task automatic prog(input int p1, input int p2, input int cfgv, input int lckv);
        wr(6'h18, 0);
        unlock(); wr(6'h0D, 2);
        unlock(); wr(6'h00, p1);
        unlock(); wr(6'h04, p2);
        wr(6'h10, cfgv);
        wr(6'h18, lckv);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        longint v;
        idle(2);
        rst_n = 1'b1; por_n = 1'b1;
        #1;
        // R1 reset state
        rd(6'h00, v); chk("R1 pv1", v, 0);
        rd(6'h04, v); chk("R1 pv2", v, 0);
        rd(6'h10, v); chk("R1 cfg", v, 0);
        rd(6'h18, v); chk("R1 lock", v, 0);
        rd(6'h14, v); chk("R1 cnt", v, 0);
        chk("R1 outputs", {stage1_irq_o, rst_cold_o, rst_warm_o}, 0);

        // R3 guarded write without unlock is ignored
        wr(6'h00, 5); rd(6'h00, v); chk("R3 no unlock", v, 0);
        // R2 accepted after unlock
        unlock(); wr(6'h00, 9); rd(6'h00, v); chk("R2 unlocked write", v, 9);
        // R4 gate consumed by one write
        wr(6'h00, 7); rd(6'h00, v); chk("R4 second write", v, 9);
        // R3 cancelled sequence
        wr(6'h0C, 32'h80); wr(6'h10, 0); wr(6'h0C, 32'h86); wr(6'h04, 3);
        rd(6'h04, v); chk("R3 cancelled", v, 0);
        // R12 disabled counter shows P1
        rd(6'h14, v); chk("R12 cnt tracks pv1", v, 9);
        // R5 configuration without unlock
        wr(6'h10, 32'h3C); rd(6'h10, v); chk("R5 cfg readback", v, 32'h3C);
        wr(6'h10, 0);

        // R7 / R8 timing sweep over preloads and both prescalers
        for (int f = 0; f < 2; f++) begin
            for (int p1 = 0; p1 < 4; p1++) begin
                for (int p2 = 0; p2 < 4; p2++) begin
                    int t, n_exp, irq_n, fl_n, pulses, pulse_at;
                    t = f ? (1 << FS) : (1 << CS);
                    n_exp = (p1 + p2 + 2) * t;
                    irq_n = -1; fl_n = -1; pulses = 0; pulse_at = -1;
                    prog(p1, p2, 32'h30 | (f ? 4 : 0), 2);
                    for (int n = 1; n <= n_exp + 3; n++) begin
                        @(posedge clk); #1;
                        if (stage1_irq_o && irq_n < 0) irq_n = n;
                        if (tout_o && fl_n < 0) fl_n = n;
                        if (rst_cold_o) begin pulses++; pulse_at = n; end
                    end
                    chk("R7 stage1 expiry cycle", irq_n, (p1 + 1) * t);
                    chk("R8 flag cycle", fl_n, n_exp);
                    chk("R8 single cold pulse", pulses * 100000 + pulse_at, 100000 + n_exp);
                    rd(6'h14, v); chk("R11 halted count", v, 0);
                end
            end
        end

        // R8 warm reset selection
        begin
            int wc, cc;
            wc = 0; cc = 0;
            prog(0, 0, 32'h38, 2);
            for (int n = 0; n < 36; n++) begin
                @(posedge clk); #1;
                wc += rst_warm_o; cc += rst_cold_o;
            end
            chk("R8 warm pulses", wc, 1);
            chk("R8 cold pulses in warm mode", cc, 0);
        end
        // R8 reset disabled: flag only
        begin
            int pc;
            pc = 0;
            prog(0, 0, 32'h20, 2);
            for (int n = 0; n < 36; n++) begin
                @(posedge clk); #1;
                pc += rst_warm_o + rst_cold_o;
            end
            chk("R8 no pulse when reset off", pc, 0);
            chk("R8 pin set", tout_o, 1);
        end

        // R11 restart after timeout
        prog(2, 0, 32'h30, 6);
        idle(64);
        chk("R11 restart flag", tout_o, 1);
        rd(6'h14, v); chk("R11 restart count", v, 2);

        // R9 periodic reload keeps it alive
        prog(1, 1, 32'h30, 2);
        for (int k = 0; k < 8; k++) begin
            idle(40); unlock(); wr(6'h0D, 1);
        end
        chk("R9 no timeout with reload", tout_o, 0);
        chk("R9 irq cleared", stage1_irq_o, 0);

        // R9 reload on the exact expiry edge wins
        prog(1, 1, 32'h30, 2);
        idle(64 - 3);
        unlock(); wr(6'h0D, 1);
        chk("R9 same-edge reload flag", tout_o, 0);
        rd(6'h14, v); chk("R9 same-edge reload count", v, 1);

        // R10 flag survives rst_n, clear rules, por_n
        prog(0, 0, 32'h30, 2);
        idle(34);
        chk("R10 timed out", tout_o, 1);
        rst_n = 1'b0; idle(1); rst_n = 1'b1;
        rd(6'h0D, v); chk("R10 flag after rst_n", v, 2);
        wr(6'h0D, 2); rd(6'h0D, v); chk("R10 clear without unlock", v, 2);
        unlock(); wr(6'h0D, 2); rd(6'h0D, v); chk("R10 guarded clear", v, 0);
        prog(0, 0, 32'h30, 2);
        idle(34);
        por_n = 1'b0; idle(1); por_n = 1'b1;
        rd(6'h0D, v); chk("R10 flag after por_n", v, 0);

        // R6 lock freezes configuration
        wr(6'h18, 0);
        unlock(); wr(6'h00, 4);
        wr(6'h10, 32'h10);
        wr(6'h18, 1);
        wr(6'h10, 32'h24);
        unlock(); wr(6'h00, 6);
        wr(6'h18, 0);
        rd(6'h10, v); chk("R6 cfg frozen", v, 32'h10);
        rd(6'h00, v); chk("R6 pv1 frozen", v, 4);
        rd(6'h18, v); chk("R6 lock stays", v, 1);
        rst_n = 1'b0; idle(1); rst_n = 1'b1;
        rd(6'h18, v); chk("R6 lock cleared by rst_n", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule